// File: doc/BRIEF.md
# Affine Block-Match Coefficient Unit

This unit scores one candidate pairing in a self-similarity image coder. It takes a block of sixteen 8-bit range pixels and a block of sixteen decimated domain pixels of the same shape. It fits the range as a scaled copy of the domain plus a constant level. The scale and the level are found in closed form by least squares, and the unit then reports the squared residual of that fit. A search engine outside the block feeds candidate domains one after another and keeps the pairing with the smallest residual.

The per-block sums are built once for each image and then stay fixed. These are the sum of pixels and the sum of squared pixels, for both the range and the domain, and the caller supplies them with each request. Only the cross-product sum between the two blocks is formed inside the unit.

A one-cycle `start` launches a job. `busy` stays high while the job runs. A one-cycle `valid` marks the cycle in which the new scale, offset and error appear. They then stay held until the next job completes. The scale comes from a sequential fixed-point divider and carries 8 fractional bits.

Top module: `afm_fit_unit`

## Requirements
- R1: After reset `busy` and `valid` are 0, and `scale`, `offset` and `err` read 0.
- R2: A `start` seen while `busy` is low raises `busy` in the next cycle. `busy` then stays high until the result is ready. `valid` is high for exactly one cycle, and that is the first cycle in which `busy` is low again.
- R3: A `start` seen while `busy` is high is ignored. The running job completes with its original operands.
- R4: Let num = 16·Σd·r − Σd·Σr and den = 16·Σd² − (Σd)². When den ≠ 0 and there is no overflow, `scale` is the signed two's-complement value of 256·num/den, truncated toward zero (Q8, 16 bits).
- R5: When |256·num/den| ≥ 32768, `scale` saturates to +32767, or to −32767 when num < 0.
- R6: When den = 0 (a flat domain), `scale` is 0 and `offset` is 16·Σr, which is the range mean in Q8.
- R7: `offset` = floor((256·Σr − scale·Σd) / 16), signed Q8, 25 bits.
- R8: `err` = Σi (scale·d_i + offset − 256·r_i)², an unsigned integer in Q16 (64 bits).
- R9: `scale`, `offset` and `err` change only in the cycle where `valid` is high. Input changes without an accepted `start` leave them untouched.
- R10: Pixel i of each block sits at bits [8i+7:8i] of its bus. Range pixel i is paired with domain pixel i. The pixels and sums are sampled only in the cycle where `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job (accepted only while idle) |
| rng_px | input | 128 | Range pixels, pixel i at bits [8i+7:8i] |
| dom_px | input | 128 | Decimated domain pixels, same packing |
| sum_r | input | 12 | Σ of range pixels |
| sum_r2 | input | 20 | Σ of squared range pixels |
| sum_d | input | 12 | Σ of domain pixels |
| sum_d2 | input | 20 | Σ of squared domain pixels |
| busy | output | 1 | Job in progress |
| valid | output | 1 | One-cycle result strobe |
| scale | output | 16 | Signed scale, Q8 |
| offset | output | 25 | Signed offset, Q8 |
| err | output | 64 | Squared fit error, Q16 |

## Verification
The cases hardest to reach from the ports are the two special paths of the scale computation. Random pixels almost never give a flat domain, and they almost never give the low-contrast domain paired with a high-contrast range that drives the quotient past its 16-bit range. The stimulus therefore mixes directed blocks with random ones: a constant domain, a domain with one pixel raised by one level, and a range that is strongly positive or strongly negative against it. It also mixes in random domains that vary by only one level, so the saturation and flat branches show up among random trials too. A second `start` with different operands is injected in the middle of a job, to show that the running result is kept.

// File: rtl/afm_pkg.sv
package afm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_DIV  = 3'd2,
        ST_OFS  = 3'd3,
        ST_ERR  = 3'd4
    } afm_state_e;
endpackage

// File: rtl/afm_dotprod.sv
module afm_dotprod #(
    parameter int PIX_W = 8,
    parameter int N_PIX = 16,
    parameter int DR_W  = 2 * PIX_W + $clog2(N_PIX)
) (
    input  logic [N_PIX*PIX_W-1:0] rng_px,
    input  logic [N_PIX*PIX_W-1:0] dom_px,
    output logic [DR_W-1:0]        sum_dr
);
    localparam int P_W = 2 * PIX_W;

    logic [P_W-1:0] prod [N_PIX];

    generate
        for (genvar i = 0; i < N_PIX; i++) begin : g_lane
            logic [P_W-1:0] a_ext;
            logic [P_W-1:0] b_ext;
            assign a_ext   = {{PIX_W{1'b0}}, rng_px[i*PIX_W +: PIX_W]};
            assign b_ext   = {{PIX_W{1'b0}}, dom_px[i*PIX_W +: PIX_W]};
            assign prod[i] = a_ext * b_ext;
        end
    endgenerate

    always_comb begin
        sum_dr = '0;
        for (int i = 0; i < N_PIX; i++) begin
            sum_dr = sum_dr + DR_W'(prod[i]);
        end
    end
endmodule

// File: rtl/afm_divider.sv
module afm_divider #(
    parameter int DVD_W = 33,
    parameter int DEN_W = 24,
    parameter int QMAG  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [QMAG-1:0]  quot
);
    localparam int CNT_W = $clog2(QMAG + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [QMAG-1:0]  low;
        logic [QMAG-1:0]  q;
        logic [DEN_W-1:0] dvs;
        logic             done;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        logic [DEN_W:0] trial;
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = '0;
        if (start && !div_q.run) begin
            div_d.run = 1'b1;
            div_d.cnt = CNT_W'(QMAG);
            div_d.rem = DEN_W'(dividend >> QMAG);
            div_d.low = dividend[QMAG-1:0];
            div_d.q   = '0;
            div_d.dvs = divisor;
        end else if (div_q.run) begin
            trial     = {div_q.rem, div_q.low[QMAG-1]};
            div_d.low = div_q.low << 1;
            if (trial >= {1'b0, div_q.dvs}) begin
                div_d.rem = DEN_W'(trial - {1'b0, div_q.dvs});
                div_d.q   = {div_q.q[QMAG-2:0], 1'b1};
            end else begin
                div_d.rem = trial[DEN_W-1:0];
                div_d.q   = {div_q.q[QMAG-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.run  = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done = div_q.done;
    assign quot = div_q.q;
endmodule

// File: rtl/afm_error.sv
module afm_error #(
    parameter int S_W   = 16,
    parameter int O_W   = 25,
    parameter int SR_W  = 12,
    parameter int SQ_W  = 20,
    parameter int FRAC  = 8,
    parameter int LOGN  = 4,
    parameter int E_W   = 64
) (
    input  logic signed [S_W-1:0] scale,
    input  logic signed [O_W-1:0] offset,
    input  logic [SR_W-1:0]       sum_r,
    input  logic [SQ_W-1:0]       sum_r2,
    input  logic [SR_W-1:0]       sum_d,
    input  logic [SQ_W-1:0]       sum_d2,
    input  logic [SQ_W-1:0]       sum_dr,
    output logic [E_W-1:0]        err_full
);
    logic signed [E_W-1:0] s, o, r, r2, d, d2, dr, acc;

    assign s  = E_W'(scale);
    assign o  = E_W'(offset);
    assign r  = E_W'(sum_r);
    assign r2 = E_W'(sum_r2);
    assign d  = E_W'(sum_d);
    assign d2 = E_W'(sum_d2);
    assign dr = E_W'(sum_dr);

    // expanded residual in Q(2*FRAC): every term uses the stored sums
    always_comb begin
        acc = s * s * d2
            + ((s * o * d) <<< 1)
            - ((s * dr) <<< (FRAC + 1))
            + ((o * o) <<< LOGN)
            - ((o * r) <<< (FRAC + 1))
            + (r2 <<< (2 * FRAC));
    end

    assign err_full = acc;
endmodule

// File: rtl/afm_fit_unit.sv
module afm_fit_unit
    import afm_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int N_PIX = 16,
    parameter int FRAC  = 8,
    parameter int S_W   = 16,
    parameter int LOGN  = $clog2(N_PIX),
    parameter int SR_W  = PIX_W + LOGN,
    parameter int SQ_W  = 2 * PIX_W + LOGN,
    parameter int O_W   = S_W + SR_W + 1 - LOGN,
    parameter int E_W   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_PIX*PIX_W-1:0]  rng_px,
    input  logic [N_PIX*PIX_W-1:0]  dom_px,
    input  logic [SR_W-1:0]         sum_r,
    input  logic [SQ_W-1:0]         sum_r2,
    input  logic [SR_W-1:0]         sum_d,
    input  logic [SQ_W-1:0]         sum_d2,
    output logic                    busy,
    output logic                    valid,
    output logic signed [S_W-1:0]   scale,
    output logic signed [O_W-1:0]   offset,
    output logic [E_W-1:0]          err
);
    localparam int QMAG  = S_W - 1;
    localparam int NUM_W = SQ_W + LOGN + 1;
    localparam int DEN_W = SQ_W + LOGN;
    localparam int DVD_W = NUM_W + FRAC;
    localparam int CMP_W = DVD_W + DEN_W + QMAG;
    localparam int T_W   = S_W + SR_W + 1;
    localparam logic signed [S_W-1:0] S_MAX = {1'b0, {QMAG{1'b1}}};

    typedef struct packed {
        afm_state_e              st;
        logic [SR_W-1:0]         sr;
        logic [SQ_W-1:0]         sr2;
        logic [SR_W-1:0]         sd;
        logic [SQ_W-1:0]         sd2;
        logic [SQ_W-1:0]         sdr;
        logic                    neg;
        logic signed [S_W-1:0]   s;
        logic signed [O_W-1:0]   o;
        logic                    valid;
        logic signed [S_W-1:0]   res_s;
        logic signed [O_W-1:0]   res_o;
        logic [E_W-1:0]          res_e;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SQ_W-1:0]         dr_now;
    logic signed [NUM_W-1:0] num;
    logic [DEN_W-1:0]        den;
    logic [NUM_W-1:0]        mag;
    logic [DVD_W-1:0]        dividend;
    logic                    ovf;
    logic                    div_start;
    logic                    div_done;
    logic [QMAG-1:0]         quot;
    logic signed [O_W-1:0]   o_next;
    logic [E_W-1:0]          err_full;

    afm_dotprod #(.PIX_W(PIX_W), .N_PIX(N_PIX), .DR_W(SQ_W)) u_dot (
        .rng_px (rng_px),
        .dom_px (dom_px),
        .sum_dr (dr_now)
    );

    // numerator and denominator of the scale from the latched sums
    always_comb begin
        logic signed [NUM_W-1:0] n_dr, n_sd, n_sr;
        n_dr = NUM_W'(ctl_q.sdr);
        n_sd = NUM_W'(ctl_q.sd);
        n_sr = NUM_W'(ctl_q.sr);
        num  = (n_dr <<< LOGN) - n_sd * n_sr;
        den  = (DEN_W'(ctl_q.sd2) << LOGN) - DEN_W'(ctl_q.sd) * DEN_W'(ctl_q.sd);
        mag  = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
        dividend = {mag, {FRAC{1'b0}}};
        ovf  = (CMP_W'(dividend) >= (CMP_W'(den) << QMAG));
    end

    assign div_start = (ctl_q.st == ST_PREP) && (den != '0) && !ovf;

    afm_divider #(.DVD_W(DVD_W), .DEN_W(DEN_W), .QMAG(QMAG)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (den),
        .done     (div_done),
        .quot     (quot)
    );

    // offset = floor((Σr<<FRAC - s*Σd) / N)
    always_comb begin
        logic signed [T_W-1:0] t_sr, t_s, t_sd, t;
        t_sr   = T_W'(ctl_q.sr);
        t_sr   = t_sr <<< FRAC;
        t_s    = T_W'(ctl_q.s);
        t_sd   = T_W'(ctl_q.sd);
        t      = t_sr - t_s * t_sd;
        o_next = O_W'(t >>> LOGN);
    end

    afm_error #(
        .S_W(S_W), .O_W(O_W), .SR_W(SR_W), .SQ_W(SQ_W),
        .FRAC(FRAC), .LOGN(LOGN), .E_W(E_W)
    ) u_err (
        .scale    (ctl_q.s),
        .offset   (ctl_q.o),
        .sum_r    (ctl_q.sr),
        .sum_r2   (ctl_q.sr2),
        .sum_d    (ctl_q.sd),
        .sum_d2   (ctl_q.sd2),
        .sum_dr   (ctl_q.sdr),
        .err_full (err_full)
    );

    always_comb begin
        logic signed [S_W-1:0] s_mag;
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        s_mag       = S_W'(quot);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st  = ST_PREP;
                    ctl_d.sr  = sum_r;
                    ctl_d.sr2 = sum_r2;
                    ctl_d.sd  = sum_d;
                    ctl_d.sd2 = sum_d2;
                    ctl_d.sdr = dr_now;
                end
            end
            ST_PREP: begin
                ctl_d.neg = num[NUM_W-1];
                if (den == '0) begin
                    ctl_d.s  = '0;
                    ctl_d.st = ST_OFS;
                end else if (ovf) begin
                    ctl_d.s  = num[NUM_W-1] ? -S_MAX : S_MAX;
                    ctl_d.st = ST_OFS;
                end else begin
                    ctl_d.st = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    ctl_d.s  = ctl_q.neg ? -s_mag : s_mag;
                    ctl_d.st = ST_OFS;
                end
            end
            ST_OFS: begin
                ctl_d.o  = o_next;
                ctl_d.st = ST_ERR;
            end
            ST_ERR: begin
                ctl_d.res_s = ctl_q.s;
                ctl_d.res_o = ctl_q.o;
                ctl_d.res_e = err_full;
                ctl_d.valid = 1'b1;
                ctl_d.st    = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy   = (ctl_q.st != ST_IDLE);
    assign valid  = ctl_q.valid;
    assign scale  = ctl_q.res_s;
    assign offset = ctl_q.res_o;
    assign err    = ctl_q.res_e;
endmodule

// File: rtl/afm_fit_chk.sv
module afm_fit_chk #(
    parameter int S_W = 16,
    parameter int O_W = 25,
    parameter int E_W = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  valid,
    input logic signed [S_W-1:0] scale,
    input logic signed [O_W-1:0] offset,
    input logic [E_W-1:0]        err
);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_end_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);

    p_stay_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !valid && start) |=> (busy || valid));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(scale) && $stable(offset) && $stable(err)));
endmodule

bind afm_fit_unit afm_fit_chk #(.S_W(S_W), .O_W(O_W), .E_W(E_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .valid  (valid),
    .scale  (scale),
    .offset (offset),
    .err    (err)
);

// File: tb/sim_afm_fit_unit.sv
`timescale 1ns/1ps
module sim_afm_fit_unit;
    localparam int PIX_W = 8;
    localparam int N     = 16;
    localparam int S_W   = 16;
    localparam int SR_W  = 12;
    localparam int SQ_W  = 20;
    localparam int O_W   = 25;
    localparam int E_W   = 64;
    localparam int BW    = N * PIX_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst_n, start;
    logic [BW-1:0]         rng_px, dom_px;
    logic [SR_W-1:0]       sum_r, sum_d;
    logic [SQ_W-1:0]       sum_r2, sum_d2;
    logic                  busy, valid;
    logic signed [S_W-1:0] scale;
    logic signed [O_W-1:0] offset;
    logic [E_W-1:0]        err;

    afm_fit_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rng_px(rng_px), .dom_px(dom_px),
        .sum_r(sum_r), .sum_r2(sum_r2), .sum_d(sum_d), .sum_d2(sum_d2),
        .busy(busy), .valid(valid), .scale(scale), .offset(offset), .err(err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint px(input logic [BW-1:0] v, input int i);
        return longint'(v[i*PIX_W +: PIX_W]);
    endfunction

    function automatic void model(input logic [BW-1:0] r, input logic [BW-1:0] d,
                                  output longint s, output longint o, output longint e);
        longint sr = 0, sd = 0, sd2 = 0, sdr = 0, num, den, mag, q, t;
        for (int i = 0; i < N; i++) begin
            sr  += px(r, i);
            sd  += px(d, i);
            sd2 += px(d, i) * px(d, i);
            sdr += px(d, i) * px(r, i);
        end
        num = 16 * sdr - sd * sr;
        den = 16 * sd2 - sd * sd;
        if (den == 0) s = 0;
        else begin
            mag = (num < 0) ? -num : num;
            q = (mag * 256) / den;
            if (q > 32767) q = 32767;
            s = (num < 0) ? -q : q;
        end
        o = (sr * 256 - s * sd) >>> 4;
        e = 0;
        for (int i = 0; i < N; i++) begin
            t = s * px(d, i) + o - 256 * px(r, i);
            e += t * t;
        end
    endfunction

    task automatic set_ops(input logic [BW-1:0] r, input logic [BW-1:0] d);
        longint a = 0, b = 0, c = 0, f = 0;
        for (int i = 0; i < N; i++) begin
            a += px(r, i); b += px(r, i) * px(r, i);
            c += px(d, i); f += px(d, i) * px(d, i);
        end
        rng_px = r; dom_px = d;
        sum_r = SR_W'(a); sum_r2 = SQ_W'(b);
        sum_d = SR_W'(c); sum_d2 = SQ_W'(f);
    endtask

    function automatic logic [BW-1:0] rand_blk(input int lo, input int span);
        logic [BW-1:0] v;
        for (int i = 0; i < N; i++) v[i*PIX_W +: PIX_W] = PIX_W'(lo + int'($urandom % span));
        return v;
    endfunction

    task automatic run(input string tag, input logic [BW-1:0] r, input logic [BW-1:0] d,
                       input bit interfere);
        longint es, eo, ee, hs, ho, he;
        int cyc;
        model(r, d, es, eo, ee);
        @(negedge clk);
        set_ops(r, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", longint'(busy), 1);
        cyc = 0;
        while (!valid && cyc < 200) begin
            if (interfere && cyc == 2) begin
                set_ops(rand_blk(0, 256), rand_blk(0, 256));
                start = 1'b1;   // R3: must be ignored
            end else begin
                start = 1'b0;
                if (interfere && cyc == 3) set_ops(rand_blk(0, 256), rand_blk(0, 256)); // R10
            end
            if (!busy) chk("R2 busy held", 0, 1);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 200) chk("R2 result timeout", 0, 1);
        chk("R2 busy low with valid", longint'(busy), 0);
        chk({tag, " scale"}, longint'(scale), es);
        chk({tag, " offset R7"}, longint'(offset), eo);
        chk({tag, " err R8"}, longint'(err), ee);
        hs = longint'(scale); ho = longint'(offset); he = longint'(err);
        @(negedge clk);
        chk("R2 valid single cycle", longint'(valid), 0);
        set_ops(rand_blk(0, 256), rand_blk(0, 256));
        repeat (3) @(negedge clk);
        chk("R9 scale held", longint'(scale), hs);
        chk("R9 offset held", longint'(offset), ho);
        chk("R9 err held", longint'(err), he);
    endtask

    initial begin
        #(8 * 200000);
        chk("watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [BW-1:0] r, d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0;
        set_ops('0, '0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 valid", longint'(valid), 0);
        chk("R1 scale", longint'(scale), 0);
        chk("R1 offset", longint'(offset), 0);
        chk("R1 err", longint'(err), 0);

        // R4 identity fit: scale 1.0, zero offset, zero error
        r = rand_blk(0, 256);
        run("R4 identity", r, r, 1'b0);
        // R4 inverted domain: scale -1.0
        d = '0;
        for (int i = 0; i < N; i++) d[i*PIX_W +: PIX_W] = 8'd255 - r[i*PIX_W +: PIX_W];
        run("R4 inverse", r, d, 1'b0);
        // R6 flat domain
        run("R6 flat", rand_blk(0, 256), {N{8'd77}}, 1'b0);
        run("R6 flat zero", rand_blk(0, 256), '0, 1'b0);
        // R5 saturation, positive then negative
        d = '0; d[7:0] = 8'd1;
        r = '0; r[7:0] = 8'd255;
        run("R5 sat pos", r, d, 1'b0);
        r = {N{8'd255}}; r[7:0] = 8'd0;
        run("R5 sat neg", r, d, 1'b0);
        // R10 lane pairing: one lane carries all the correlation
        d = '0; d[5*PIX_W +: PIX_W] = 8'd200;
        run("R10 lane", rand_blk(0, 256), d, 1'b0);
        // R3 start during busy ignored
        run("R3 ignore", rand_blk(0, 256), rand_blk(0, 256), 1'b1);
        // random trials, some with low-contrast domains
        for (int k = 0; k < 40; k++) begin
            if (k % 4 == 3) run("R5 R4 lowcontrast", rand_blk(0, 256), rand_blk(int'($urandom % 250), 2), 1'b0);
            else            run("R4 random", rand_blk(0, 256), rand_blk(0, 256), (k % 5) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule